// File: doc/BRIEF.md
# Multi-Word Integer Arithmetic Engine

This engine adds, subtracts, multiplies or squares unsigned integers that span many 32-bit words. The words live in a local single-port RAM, least significant word at the lowest address. Privileged software first loads the operands into the RAM through a host port. It then sets three base addresses (first operand, second operand, destination) and a word count. Writing an operation code into the command register launches the job. The engine walks the operands one word at a time and keeps the carry, borrow or partial-product carry between words.

Software polls a status register for completion. A separate abort input stops a running job at the next word the engine writes. Every register and RAM access is refused unless the privilege input is high. The RAM port is also closed to the host while a job runs.

Top module: `bigvec_engine`

Register offsets on `reg_addr`: 0 first-operand base, 1 second-operand base, 2 destination base, 3 word count, 4 command (2-bit code, written to start), 5 status. Status bits: bit 0 busy, bit 1 done, bit 2 aborted, bit 3 final carry/borrow. Command codes: 0 add, 1 subtract, 2 multiply, 3 square.

## Requirements
- R1: When `priv` is low, register writes, command writes and RAM writes have no effect. `reg_rdata` reads 0 one cycle later, and a RAM read returns 0.
- R2: A privileged write to offset 4 with a nonzero word count sets busy in the next cycle. Register writes made while busy is set are ignored.
- R3: Code 0 writes A+B to the n destination words and places the carry out of the top word in status bit 3.
- R4: Code 1 writes A−B modulo 2^(32n) to the n destination words and places the final borrow in status bit 3.
- R5: Code 2 writes the full 2n-word product A×B. Any earlier contents of the destination are replaced.
- R6: Code 3 writes the 2n-word square of A and ignores the second-operand base.
- R7: At the end of a job, busy clears and done sets. Done stays set until the next start, which clears done, aborted and carry.
- R8: An abort request during a job ends it after the word being written. Busy clears, aborted sets, done stays clear, and words not yet reached are left unchanged.
- R9: A word count of 0 sets done in the cycle after the command write, never sets busy and writes no RAM word.
- R10: After reset, all registers and the status read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv | input | 1 | High when the requester is privileged |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_addr` |
| mem_en | input | 1 | Host RAM access request |
| mem_wr | input | 1 | Host RAM write (with `mem_en`) |
| mem_addr | input | ADDR_W | Host RAM word address |
| mem_wdata | input | 32 | Host RAM write data |
| mem_rdata | output | 32 | Host RAM read data, one cycle after the request |
| abort_req | input | 1 | Request to stop the running job |

## Verification
A carry that is lost between words shows up in the very next destination word. In add and subtract it also shows up in the final flag. A fault in the row or column counters of the multiplier shows up in the upper half of the product, so every multiply check reads all 2n words back. If the destination is not cleared first, old data leaks into the product, so it is seeded with garbage beforehand. A broken abort path or privilege gate shows up at once in the status word, in a register read back, or in a sentinel RAM word read after the event.

// File: rtl/bv_pkg.sv
package bv_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_SQR = 2'd3
  } bv_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADD_RA, ST_ADD_RB, ST_ADD_WR,
    ST_CLR, ST_M_RA, ST_M_RB, ST_M_RR, ST_M_WR, ST_M_TOP
  } bv_state_e;

  localparam logic [2:0] REG_ABASE = 3'd0;
  localparam logic [2:0] REG_BBASE = 3'd1;
  localparam logic [2:0] REG_RBASE = 3'd2;
  localparam logic [2:0] REG_LEN   = 3'd3;
  localparam logic [2:0] REG_OP    = 3'd4;
  localparam logic [2:0] REG_STAT  = 3'd5;
endpackage

// File: rtl/bv_ram.sv
module bv_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/bv_alu.sv
module bv_alu #(
  parameter int DATA_W = 32
) (
  input  logic              mul_mode,
  input  logic              sub_mode,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] cin,
  output logic [DATA_W-1:0] res,
  output logic [DATA_W-1:0] cout
);
  localparam int PW = 2 * DATA_W;
  logic [PW-1:0]   prod;
  logic [DATA_W:0] ext;

  always_comb begin
    // a*b + acc + cin never exceeds 2^PW - 1
    prod = PW'(a) * PW'(b) + PW'(acc) + PW'(cin);
    if (sub_mode) ext = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin[0]};
    else          ext = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin[0]};
    if (mul_mode) begin
      res  = prod[DATA_W-1:0];
      cout = prod[PW-1:DATA_W];
    end else begin
      res  = ext[DATA_W-1:0];
      cout = {{(DATA_W-1){1'b0}}, ext[DATA_W]};
    end
  end
endmodule

// File: rtl/bv_seq.sv
module bv_seq
  import bv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] a_base,
  input  logic [ADDR_W-1:0] b_base,
  input  logic [ADDR_W-1:0] r_base,
  input  logic [ADDR_W-1:0] len,
  input  logic              abort_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_q,
  output logic              busy,
  output logic              done,
  output logic              aborted,
  output logic              flag
);
  bv_state_e         state;
  logic [ADDR_W-1:0] i, j;
  logic [ADDR_W:0]   k;
  logic [DATA_W-1:0] opa, opb, carry;
  logic              abort_pend, is_sub, is_sqr;
  logic [DATA_W-1:0] alu_b, alu_res, alu_cout;
  logic [ADDR_W-1:0] b_src, last_idx;
  logic [ADDR_W:0]   clr_last;
  logic              stop;

  assign b_src    = is_sqr ? a_base : b_base;
  assign last_idx = len - 1'b1;
  assign clr_last = {len, 1'b0} - 1'b1;
  assign stop     = abort_pend | abort_req;
  assign alu_b    = (state == ST_ADD_WR) ? mem_q : opb;

  bv_alu #(.DATA_W(DATA_W)) u_alu (
    .mul_mode (state == ST_M_WR),
    .sub_mode (is_sub),
    .a        (opa),
    .b        (alu_b),
    .acc      (mem_q),
    .cin      (carry),
    .res      (alu_res),
    .cout     (alu_cout)
  );

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = a_base + i;
    mem_wdata = alu_res;
    case (state)
      ST_ADD_RB: mem_addr = b_base + i;
      ST_ADD_WR: begin mem_we = 1'b1; mem_addr = r_base + i; end
      ST_CLR:    begin mem_we = 1'b1; mem_addr = r_base + k[ADDR_W-1:0]; mem_wdata = '0; end
      ST_M_RB:   mem_addr = b_src + j;
      ST_M_RR:   mem_addr = r_base + i + j;
      ST_M_WR:   begin mem_we = 1'b1; mem_addr = r_base + i + j; end
      ST_M_TOP:  begin mem_we = 1'b1; mem_addr = r_base + i + len; mem_wdata = carry; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; i <= '0; j <= '0; k <= '0;
      opa <= '0; opb <= '0; carry <= '0;
      abort_pend <= 1'b0; is_sub <= 1'b0; is_sqr <= 1'b0;
      busy <= 1'b0; done <= 1'b0; aborted <= 1'b0; flag <= 1'b0;
    end else begin
      if (busy && abort_req) abort_pend <= 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          done <= 1'b0; aborted <= 1'b0; flag <= 1'b0; abort_pend <= 1'b0;
          i <= '0; j <= '0; k <= '0; carry <= '0;
          is_sub <= (op == OP_SUB);
          is_sqr <= (op == OP_SQR);
          if (len == '0) done <= 1'b1;
          else begin
            busy  <= 1'b1;
            state <= (op == OP_ADD || op == OP_SUB) ? ST_ADD_RA : ST_CLR;
          end
        end
        ST_ADD_RA: state <= ST_ADD_RB;
        ST_ADD_RB: begin opa <= mem_q; state <= ST_ADD_WR; end
        ST_ADD_WR: begin
          carry <= alu_cout;
          if (i == last_idx) begin
            flag <= alu_cout[0]; busy <= 1'b0; done <= 1'b1; state <= ST_IDLE;
          end else if (stop) begin
            busy <= 1'b0; aborted <= 1'b1; state <= ST_IDLE;
          end else begin
            i <= i + 1'b1; state <= ST_ADD_RA;
          end
        end
        ST_CLR: begin
          if (k == clr_last) begin
            state <= ST_M_RA;
          end else if (stop) begin
            busy <= 1'b0; aborted <= 1'b1; state <= ST_IDLE;
          end else k <= k + 1'b1;
        end
        ST_M_RA: state <= ST_M_RB;
        ST_M_RB: begin opa <= mem_q; state <= ST_M_RR; end
        ST_M_RR: begin opb <= mem_q; state <= ST_M_WR; end
        ST_M_WR: begin
          carry <= alu_cout;
          if (j == last_idx) state <= ST_M_TOP;
          else if (stop) begin
            busy <= 1'b0; aborted <= 1'b1; state <= ST_IDLE;
          end else begin
            j <= j + 1'b1; state <= ST_M_RA;
          end
        end
        ST_M_TOP: begin
          if (i == last_idx) begin
            busy <= 1'b0; done <= 1'b1; state <= ST_IDLE;
          end else if (stop) begin
            busy <= 1'b0; aborted <= 1'b1; state <= ST_IDLE;
          end else begin
            i <= i + 1'b1; j <= '0; carry <= '0; state <= ST_M_RA;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a running job never shows a stale done or aborted flag
  assert_running_clean_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(done || aborted));
  // R8: every job end is reported as exactly one of done or aborted
  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done != aborted));
  // R9: an empty job finishes at once without becoming busy
  assert_empty_job_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && len == '0) |=> (done && !busy));
endmodule

// File: rtl/bigvec_engine.sv
module bigvec_engine
  import bv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = bv_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              priv,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              mem_en,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata,
  input  logic              abort_req
);
  logic [ADDR_W-1:0] a_base, b_base, r_base, len_q;
  logic [1:0]        op_q;
  logic              busy, done, aborted, flag;
  logic              cfg_wr, start, host_ok, host_rd_q;
  logic              eng_we, ram_we;
  logic [ADDR_W-1:0] eng_addr, ram_addr;
  logic [DATA_W-1:0] eng_wdata, ram_wdata, ram_q;
  logic              unused_wd;

  assign unused_wd = ^reg_wdata[DATA_W-1:ADDR_W];
  assign cfg_wr    = priv && reg_wr && !busy;
  assign start     = cfg_wr && (reg_addr == REG_OP);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_base <= '0; b_base <= '0; r_base <= '0; len_q <= '0; op_q <= '0;
    end else if (cfg_wr) begin
      case (reg_addr)
        REG_ABASE: a_base <= reg_wdata[ADDR_W-1:0];
        REG_BBASE: b_base <= reg_wdata[ADDR_W-1:0];
        REG_RBASE: r_base <= reg_wdata[ADDR_W-1:0];
        REG_LEN:   len_q  <= reg_wdata[ADDR_W-1:0];
        REG_OP:    op_q   <= reg_wdata[1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !priv) reg_rdata <= '0;
    else begin
      case (reg_addr)
        REG_ABASE: reg_rdata <= DATA_W'(a_base);
        REG_BBASE: reg_rdata <= DATA_W'(b_base);
        REG_RBASE: reg_rdata <= DATA_W'(r_base);
        REG_LEN:   reg_rdata <= DATA_W'(len_q);
        REG_OP:    reg_rdata <= DATA_W'(op_q);
        REG_STAT:  reg_rdata <= DATA_W'({flag, aborted, done, busy});
        default:   reg_rdata <= '0;
      endcase
    end
  end

  bv_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk, .rst, .start,
    .op        (reg_wdata[1:0]),
    .a_base, .b_base, .r_base,
    .len       (len_q),
    .abort_req,
    .mem_we    (eng_we),
    .mem_addr  (eng_addr),
    .mem_wdata (eng_wdata),
    .mem_q     (ram_q),
    .busy, .done, .aborted, .flag
  );

  assign host_ok   = priv && mem_en && !busy;
  assign ram_we    = busy ? eng_we : (host_ok && mem_wr);
  assign ram_addr  = busy ? eng_addr : mem_addr;
  assign ram_wdata = busy ? eng_wdata : mem_wdata;

  bv_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk, .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) host_rd_q <= 1'b0;
    else     host_rd_q <= host_ok && !mem_wr;
  end
  assign mem_rdata = host_rd_q ? ram_q : '0;

  // R1: nothing is readable without privilege
  assert_locked_read_R1: assert property (@(posedge clk) disable iff (rst)
    !priv |=> (reg_rdata == '0 && mem_rdata == '0));
  // R2: a command with nonzero length makes the engine busy
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (start && len_q != '0) |=> busy);
endmodule

// File: tb/bigvec_engine_bench.sv
module bigvec_engine_bench;
  import bv_pkg::*;

  logic        clk = 1'b0;
  logic        rst, priv, reg_wr, mem_en, mem_wr, abort_req;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mem_wdata, mem_rdata;
  logic [7:0]  mem_addr;
  int          checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  always #2.5 clk = ~clk;

  bigvec_engine u_bigvec_engine (
    .clk, .rst, .priv, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_en, .mem_wr, .mem_addr, .mem_wdata, .mem_rdata, .abort_req
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a host read returns
  always @(posedge clk) rd_d <= mem_en && !mem_wr;
  always @(negedge clk) if (rd_d) begin
    if (exp_q.size() == 0) check("scoreboard-empty", mem_rdata, 32'hx);
    else check(tag_q.pop_front(), mem_rdata, exp_q.pop_front());
  end

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic mem_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); mem_en = 1'b1; mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
    @(negedge clk); mem_en = 1'b0; mem_wr = 1'b0;
  endtask

  // driver: queue the expected word, then issue the read
  task automatic expect_mem(logic [7:0] a, logic [31:0] v, string tag);
    exp_q.push_back(v); tag_q.push_back(tag);
    @(negedge clk); mem_en = 1'b1; mem_wr = 1'b0; mem_addr = a;
    @(negedge clk); mem_en = 1'b0;
  endtask

  task automatic setup(logic [7:0] a, logic [7:0] b, logic [7:0] r, logic [7:0] n);
    reg_write(REG_ABASE, {24'd0, a}); reg_write(REG_BBASE, {24'd0, b});
    reg_write(REG_RBASE, {24'd0, r}); reg_write(REG_LEN, {24'd0, n});
  endtask

  task automatic wait_idle(output logic [31:0] st);
    st = 32'h1;
    for (int n = 0; n < 5000 && st[0]; n++) reg_read(REG_STAT, st);
  endtask

  task automatic run(logic [1:0] op, output logic [31:0] st);
    reg_write(REG_OP, {30'd0, op});
    wait_idle(st);
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] st, v;
    rst = 1'b1; priv = 1'b1; reg_wr = 1'b0; mem_en = 1'b0; mem_wr = 1'b0;
    abort_req = 1'b0; reg_addr = '0; reg_wdata = '0; mem_addr = '0; mem_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    reg_read(REG_STAT, st);  check("R10 status", st, 32'h0);
    reg_read(REG_ABASE, v);  check("R10 abase", v, 32'h0);
    reg_read(REG_LEN, v);    check("R10 length", v, 32'h0);

    // R3 add: carry ripples through two words
    mem_write(8'h00, 32'hffffffff); mem_write(8'h01, 32'hffffffff); mem_write(8'h02, 32'h0);
    mem_write(8'h10, 32'h1); mem_write(8'h11, 32'h0); mem_write(8'h12, 32'h0);
    setup(8'h00, 8'h10, 8'h20, 8'd3);
    run(OP_ADD, st);
    check("R3 status no carry", st, 32'h2);
    expect_mem(8'h20, 32'h0, "R3 w0"); expect_mem(8'h21, 32'h0, "R3 w1");
    expect_mem(8'h22, 32'h1, "R3 w2");
    reg_write(REG_LEN, 32'd2);
    run(OP_ADD, st);
    check("R3 status carry out", st, 32'ha);
    expect_mem(8'h20, 32'h0, "R3 wrap w0"); expect_mem(8'h21, 32'h0, "R3 wrap w1");

    // R4 subtract
    mem_write(8'h30, 32'd5); mem_write(8'h31, 32'd7);
    setup(8'h30, 8'h10, 8'h20, 8'd2);
    run(OP_SUB, st);
    check("R4 status no borrow", st, 32'h2);
    expect_mem(8'h20, 32'd4, "R4 w0"); expect_mem(8'h21, 32'd7, "R4 w1");
    setup(8'h10, 8'h30, 8'h20, 8'd2);
    run(OP_SUB, st);
    check("R4 status borrow", st, 32'ha);
    expect_mem(8'h20, 32'hfffffffc, "R4 neg w0"); expect_mem(8'h21, 32'hfffffff8, "R4 neg w1");

    // R5 multiply, destination seeded with garbage
    mem_write(8'h40, 32'd2); mem_write(8'h41, 32'd3);
    mem_write(8'h50, 32'd5); mem_write(8'h51, 32'd7);
    for (int n = 0; n < 4; n++) mem_write(8'h60 + 8'(n), 32'hdeadbeef);
    setup(8'h40, 8'h50, 8'h60, 8'd2);
    run(OP_MUL, st);
    check("R5 R7 status done", st, 32'h2);
    expect_mem(8'h60, 32'd10, "R5 w0"); expect_mem(8'h61, 32'd29, "R5 w1");
    expect_mem(8'h62, 32'd21, "R5 w2"); expect_mem(8'h63, 32'd0, "R5 w3");
    setup(8'h00, 8'h00, 8'h70, 8'd1);
    run(OP_MUL, st);
    expect_mem(8'h70, 32'h1, "R5 1w lo"); expect_mem(8'h71, 32'hfffffffe, "R5 1w hi");

    // R6 square, second base points at unrelated data
    setup(8'h00, 8'h40, 8'h70, 8'd2);
    run(OP_SQR, st);
    check("R6 status", st, 32'h2);
    expect_mem(8'h70, 32'h1, "R6 w0"); expect_mem(8'h71, 32'h0, "R6 w1");
    expect_mem(8'h72, 32'hfffffffe, "R6 w2"); expect_mem(8'h73, 32'hffffffff, "R6 w3");
    setup(8'h40, 8'h00, 8'h70, 8'd2);
    run(OP_SQR, st);
    expect_mem(8'h70, 32'd4, "R6 small w0"); expect_mem(8'h71, 32'd12, "R6 small w1");
    expect_mem(8'h72, 32'd9, "R6 small w2"); expect_mem(8'h73, 32'd0, "R6 small w3");

    // R9 zero length
    mem_write(8'h80, 32'h12345678);
    setup(8'h00, 8'h10, 8'h80, 8'd0);
    reg_write(REG_OP, {30'd0, OP_ADD});
    reg_read(REG_STAT, st);
    check("R9 immediate done", st, 32'h2);
    expect_mem(8'h80, 32'h12345678, "R9 untouched");

    // R2 R7 busy while running, config locked
    setup(8'h00, 8'h00, 8'h90, 8'd16);
    reg_write(REG_OP, {30'd0, OP_MUL});
    reg_read(REG_STAT, st);
    check("R2 R7 busy, done cleared", st, 32'h1);
    reg_write(REG_ABASE, 32'h55);
    wait_idle(st);
    check("R7 done after long job", st, 32'h2);
    reg_read(REG_ABASE, v);
    check("R2 write while busy ignored", v, 32'h0);

    // R8 abort during the clearing phase
    mem_write(8'haf, 32'hcafef00d);
    reg_write(REG_OP, {30'd0, OP_MUL});
    repeat (6) @(negedge clk);
    abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
    wait_idle(st);
    check("R8 aborted status", st, 32'h4);
    expect_mem(8'haf, 32'hcafef00d, "R8 unreached word kept");

    // R1 privilege
    priv = 1'b0;
    reg_write(REG_ABASE, 32'h77);
    reg_write(REG_OP, {30'd0, OP_ADD});
    reg_read(REG_ABASE, v);
    check("R1 read without privilege", v, 32'h0);
    mem_write(8'h80, 32'hffff0000);
    expect_mem(8'h80, 32'h0, "R1 ram read without privilege");
    priv = 1'b1;
    reg_read(REG_ABASE, v);
    check("R1 register write refused", v, 32'h0);
    reg_read(REG_STAT, st);
    check("R1 command refused", st, 32'h4);
    expect_mem(8'h80, 32'h12345678, "R1 ram write refused");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard-drain", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule